// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Status Flags

This block is the integer execute slice of a scalar core. Each cycle it takes a destination operand, a source operand, an operation code, an operand size of 8, 16 or 32 bits and an incoming carry. It returns a combinational result together with a result-write strobe. The six status flags it produces are held in a flag register, which is loaded at the next clock edge when the flag-write enable is high.

The operations are plain add, add with carry, subtract, subtract with borrow, increment, decrement, compare, negate, AND, OR, XOR and NOT. Each operation has its own rule for the flags. Increment and decrement keep the stored carry. The bitwise operations clear carry, overflow and auxiliary carry. NOT leaves all flags alone. Compare changes only the flags and raises no result write. All flags are taken from the selected operand size, and result bits above that size read as zero.

Top module: `xalu_core`

## Requirements
- R1: Opcode 0 (add) returns dst+src. Opcode 1 (add with carry) returns dst+src+carry_i. CF is the carry out of the top bit of the selected size, and OF is signed overflow.
- R2: Opcode 2 (subtract) returns dst-src. Opcode 3 (subtract with borrow) returns dst-src-carry_i. CF is set when the unsigned subtraction needs a borrow, and OF is signed overflow.
- R3: Opcode 4 (increment) returns dst+1 and opcode 5 (decrement) returns dst-1. OF, SF, ZF, AF and PF are updated, and CF keeps the value stored before the operation.
- R4: Opcode 6 (compare) loads the same flags as subtract, but res_we_o stays 0.
- R5: Opcode 7 (negate) returns 0-dst. CF is set exactly when dst, within the selected size, is nonzero.
- R6: Opcodes 8, 9 and 10 (AND, OR, XOR) return the bitwise result, set CF, OF and AF to 0, and update SF, ZF and PF.
- R7: Opcode 11 (NOT) returns the one's complement of dst, and the flag register stays unchanged even when flag_we_i is high.
- R8: size_i selects 8 bits (0), 16 bits (1) or 32 bits (2 or 3). SF is the top bit of that size, ZF and CF come from that size, and result bits above it read as 0.
- R9: PF is 1 when the low 8 result bits hold an even number of ones. AF is the carry out of, or borrow into, bit 3 for arithmetic operations.
- R10: While flag_we_i is 0 the flag register holds. Opcodes 12 to 15 return 0, keep res_we_o at 0 and leave the flags unchanged.
- R11: After reset the flag register reads 0. flags_o bits are [0]=CF, [1]=PF, [2]=AF, [3]=ZF, [4]=SF, [5]=OF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| dst_i | input | 32 | Destination (first) operand |
| src_i | input | 32 | Source (second) operand |
| carry_i | input | 1 | Incoming carry used by add and subtract with carry |
| flag_we_i | input | 1 | Load computed flags at the next edge |
| res_o | output | 32 | Combinational result, zero above the selected size |
| res_we_o | output | 1 | Result is to be written back |
| flags_o | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |

## Verification
Random operands are drawn at every size. The arithmetic operations are mixed with both values of the incoming carry, which shows whether add and subtract with carry really use it and whether each size takes its carry and sign from the correct bit. Directed cases hit the edges where flags change: an 8-bit wrap to zero with carry set, signed overflow at 0x7F+1, borrows at 0-1, increment across 0xFF while the stored carry is clear, and negation of zero. Random flag-write masking, NOT and the unused opcodes show that the flag register holds when it must. Compare shows that flags change while no write is raised.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
  localparam int DW      = 32;
  localparam int NFLAG   = 6;
  localparam int OPW     = 4;
  localparam int SZW     = 2;
  localparam int NIBW    = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBB = 4'd3,
    OP_INC = 4'd4, OP_DEC = 4'd5, OP_CMP = 4'd6, OP_NEG = 4'd7,
    OP_AND = 4'd8, OP_OR  = 4'd9, OP_XOR = 4'd10, OP_NOT = 4'd11
  } op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  function automatic logic [DW-1:0] size_mask(input logic [SZW-1:0] sz);
    case (sz)
      2'd0:    size_mask = DW'(32'h0000_00FF);
      2'd1:    size_mask = DW'(32'h0000_FFFF);
      default: size_mask = {DW{1'b1}};
    endcase
  endfunction

  function automatic logic top_bit(input logic [DW-1:0] v, input logic [SZW-1:0] sz);
    case (sz)
      2'd0:    top_bit = v[7];
      2'd1:    top_bit = v[15];
      default: top_bit = v[DW-1];
    endcase
  endfunction
endpackage

// File: rtl/xalu_addsub.sv
module xalu_addsub
  import xalu_pkg::*;
(
  input  logic [DW-1:0]  x_i,
  input  logic [DW-1:0]  y_i,
  input  logic           sub_i,
  input  logic           cin_i,
  input  logic [SZW-1:0] size_i,
  output logic [DW-1:0]  res_o,
  output logic           cry_o,
  output logic           ovf_o,
  output logic           aux_o
);
  logic [DW-1:0] mask;
  logic [DW-1:0] xm, ym;
  logic [DW:0]   sum;
  logic          cout;
  logic          msb_cin;

  always_comb begin
    mask = size_mask(size_i);
    xm   = x_i & mask;
    ym   = (sub_i ? ~y_i : y_i) & mask;
    sum  = {1'b0, xm} + {1'b0, ym} + {{DW{1'b0}}, cin_i};
    case (size_i)
      2'd0:    cout = sum[8];
      2'd1:    cout = sum[16];
      default: cout = sum[DW];
    endcase
    res_o   = sum[DW-1:0] & mask;
    msb_cin = top_bit(xm, size_i) ^ top_bit(ym, size_i) ^ top_bit(res_o, size_i);
    ovf_o   = msb_cin ^ cout;
    cry_o   = cout ^ sub_i;
    aux_o   = xm[NIBW] ^ ym[NIBW] ^ sum[NIBW] ^ sub_i;
  end
endmodule

// File: rtl/xalu_logic.sv
module xalu_logic
  import xalu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [SZW-1:0] size_i,
  output logic [DW-1:0]  res_o
);
  logic [DW-1:0] raw;

  always_comb begin
    case (op_i)
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      default: raw = ~a_i;
    endcase
    res_o = raw & size_mask(size_i);
  end
endmodule

// File: rtl/xalu_status.sv
module xalu_status
  import xalu_pkg::*;
#(
  parameter int PAR_BITS = 8
) (
  input  logic [DW-1:0]  res_i,
  input  logic [SZW-1:0] size_i,
  output logic           sgn_o,
  output logic           zro_o,
  output logic           par_o
);
  logic [PAR_BITS:0] pchain;

  assign pchain[0] = 1'b1;
  for (genvar i = 0; i < PAR_BITS; i++) begin : g_par
    assign pchain[i+1] = pchain[i] ^ res_i[i];
  end

  always_comb begin
    sgn_o = top_bit(res_i, size_i);
    zro_o = ~|(res_i & size_mask(size_i));
    par_o = pchain[PAR_BITS];
  end
endmodule

// File: rtl/xalu_core.sv
module xalu_core
  import xalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_i,
  input  logic [1:0]       size_i,
  input  logic [31:0]      dst_i,
  input  logic [31:0]      src_i,
  input  logic             carry_i,
  input  logic             flag_we_i,
  output logic [31:0]      res_o,
  output logic             res_we_o,
  output logic [5:0]       flags_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  logic [DW-1:0] as_x, as_y, as_res, lg_res, sel_res;
  logic          as_sub, as_cin, as_cry, as_ovf, as_aux;
  logic          is_arith, is_logic, is_incdec, op_valid;
  logic          st_sgn, st_zro, st_par;
  flags_t        flags_q, flags_d;
  logic          flags_en;

  always_comb begin
    as_x   = dst_i;
    as_y   = src_i;
    as_sub = 1'b0;
    as_cin = 1'b0;
    case (op_i)
      OP_ADC:          as_cin = carry_i;
      OP_SUB, OP_CMP:  begin as_sub = 1'b1; as_cin = 1'b1; end
      OP_SBB:          begin as_sub = 1'b1; as_cin = ~carry_i; end
      OP_INC:          as_y = DW'(1);
      OP_DEC:          begin as_y = DW'(1); as_sub = 1'b1; as_cin = 1'b1; end
      OP_NEG:          begin as_x = '0; as_y = dst_i; as_sub = 1'b1; as_cin = 1'b1; end
      default:         ;
    endcase
  end

  xalu_addsub u_addsub (
    .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .cin_i(as_cin), .size_i(size_i),
    .res_o(as_res), .cry_o(as_cry), .ovf_o(as_ovf), .aux_o(as_aux)
  );

  xalu_logic u_logic (
    .op_i(op_i), .a_i(dst_i), .b_i(src_i), .size_i(size_i), .res_o(lg_res)
  );

  always_comb begin
    is_arith  = (op_i <= OP_NEG);
    is_logic  = (op_i >= OP_AND) && (op_i <= OP_NOT);
    is_incdec = (op_i == OP_INC) || (op_i == OP_DEC);
    op_valid  = is_arith || is_logic;
    sel_res   = is_arith ? as_res : (is_logic ? lg_res : '0);
  end

  xalu_status #(.PAR_BITS(8)) u_status (
    .res_i(sel_res), .size_i(size_i),
    .sgn_o(st_sgn), .zro_o(st_zro), .par_o(st_par)
  );

  always_comb begin
    flags_d     = flags_q;
    flags_d.sgn = st_sgn;
    flags_d.zro = st_zro;
    flags_d.par = st_par;
    if (is_arith) begin
      flags_d.ovf = as_ovf;
      flags_d.aux = as_aux;
      flags_d.cry = is_incdec ? flags_q.cry : as_cry;
    end else begin
      flags_d.ovf = 1'b0;
      flags_d.aux = 1'b0;
      flags_d.cry = 1'b0;
    end
    flags_en = flag_we_i && op_valid && (op_i != OP_NOT);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign res_o    = sel_res;
  assign res_we_o = op_valid && (op_i != OP_CMP);
  assign flags_o  = flags_q;

  p_cmp_no_write_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_CMP) |-> !res_we_o);

  p_not_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_NOT) |=> $stable(flags_o));

  p_incdec_keeps_cf_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_incdec && flag_we_i) |=> (flags_o[0] == $past(flags_o[0])));

  p_logic_clears_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ((op_i >= OP_AND) && (op_i <= OP_XOR) && flag_we_i) |=>
      (flags_o[0] == 1'b0 && flags_o[5] == 1'b0 && flags_o[2] == 1'b0));

  p_hold_no_we_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (size_i == 2'd0) |-> (res_o[31:8] == 24'd0));

  p_neg_cf_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ((op_i == OP_NEG) && flag_we_i) |=>
      (flags_o[0] == $past(|(dst_i & size_mask(size_i)))));
endmodule

// File: tb/xalu_core_bench.sv
`timescale 1ns/1ps
module xalu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op;
  logic [1:0]  sz;
  logic [31:0] dst, src;
  logic        cin, fwe;
  logic [31:0] res;
  logic        res_we;
  logic [5:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_flags;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  xalu_core u_xalu_core (
    .clk(clk), .rst_n(rst_n), .op_i(op), .size_i(sz), .dst_i(dst), .src_i(src),
    .carry_i(cin), .flag_we_i(fwe), .res_o(res), .res_we_o(res_we), .flags_o(flags)
  );

  function automatic longint mask_of(input logic [1:0] s);
    case (s)
      2'd0:    return 64'hFF;
      2'd1:    return 64'hFFFF;
      default: return 64'hFFFF_FFFF;
    endcase
  endfunction

  function automatic longint sx(input longint v, input longint m);
    longint sbit;
    sbit = m ^ (m >> 1);
    return ((v & sbit) != 0) ? v - m - 1 : v;
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1:        return "R1";
      4'd2, 4'd3:        return "R2";
      4'd4, 4'd5:        return "R3";
      4'd6:              return "R4";
      4'd7:              return "R5";
      4'd8, 4'd9, 4'd10: return "R6";
      4'd11:             return "R7";
      default:           return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [1:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic ci, input logic [5:0] prev,
                       output logic we, output logic [31:0] r, output logic [5:0] fl);
    longint m, ua, ub, full, sr, smax, smin;
    int c;
    logic is_add, is_sub, cy, ov, ax, sg, zr, pr;
    m = mask_of(s); ua = longint'(a) & m; ub = longint'(b) & m;
    smax = m >> 1; smin = -smax - 1;
    is_add = 0; is_sub = 0; c = 0; cy = 0; ov = 0; ax = 0; full = 0;
    we = 1'b1; fl = prev;
    case (o)
      4'd0: is_add = 1;
      4'd1: begin is_add = 1; c = int'(ci); end
      4'd2, 4'd6: is_sub = 1;
      4'd3: begin is_sub = 1; c = int'(ci); end
      4'd4: begin is_add = 1; ub = 1; end
      4'd5: begin is_sub = 1; ub = 1; end
      4'd7: begin is_sub = 1; ub = ua; ua = 0; end
      4'd8:  full = ua & ub;
      4'd9:  full = ua | ub;
      4'd10: full = ua ^ ub;
      4'd11: full = (~ua) & m;
      default: we = 1'b0;
    endcase
    if (is_add) begin
      full = ua + ub + c; cy = full > m;
      sr = sx(ua, m) + sx(ub, m) + c;
      ax = ((ua & 15) + (ub & 15) + c) > 15;
    end else if (is_sub) begin
      full = ua - ub - c; cy = full < 0;
      sr = sx(ua, m) - sx(ub, m) - c;
      ax = ((ua & 15) - (ub & 15) - c) < 0;
    end else sr = 0;
    ov = (is_add || is_sub) && (sr > smax || sr < smin);
    r  = we ? 32'(full & m) : 32'd0;
    sg = ((longint'(r) & (m ^ (m >> 1))) != 0);
    zr = (r == 32'd0);
    pr = ~^r[7:0];
    if (o == 4'd6) we = 1'b0;
    if (o <= 4'd10) begin
      if (o == 4'd4 || o == 4'd5) cy = prev[0];
      fl = {ov, sg, zr, ax, pr, cy};
    end
  endtask

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h (op=%0d size=%0d dst=0x%0h src=0x%0h cin=%0b)",
               rq, act, exp, op, sz, dst, src, cin);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [1:0] s, input logic [31:0] a,
                     input logic [31:0] b, input logic ci, input logic we_f);
    logic e_we;
    logic [31:0] e_r;
    logic [5:0] e_fl;
    @(negedge clk);
    op = o; sz = s; dst = a; src = b; cin = ci; fwe = we_f;
    model(o, s, a, b, ci, exp_flags, e_we, e_r, e_fl);
    #1;
    chk(req_of(o), longint'(res_we), longint'(e_we));
    chk(req_of(o), longint'(res), longint'(e_r));
    chk("R8", longint'(res) & ~mask_of(s) & 64'hFFFF_FFFF, 0);
    if (we_f) exp_flags = e_fl;
    @(posedge clk); #1;
    if (!we_f)            chk("R10", longint'(flags), longint'(exp_flags));
    else if (o <= 4'd10) begin
      chk(req_of(o), longint'(flags), longint'(exp_flags));
      chk("R9", longint'(flags[2:1]), longint'(exp_flags[2:1]));
    end else              chk(req_of(o), longint'(flags), longint'(exp_flags));
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; op = '0; sz = '0; dst = '0; src = '0; cin = 0; fwe = 0;
    exp_flags = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", longint'(flags), 0);

    // R1 / R9: 8-bit wrap to zero with carry in
    run(4'd1, 2'd0, 32'hFF, 32'h00, 1'b1, 1'b1);
    // R1: signed overflow 0x7F+1
    run(4'd0, 2'd0, 32'h7F, 32'h01, 1'b0, 1'b1);
    // R3: increment across 0xFF after a clean add left CF=0
    run(4'd0, 2'd0, 32'h01, 32'h01, 1'b0, 1'b1);
    run(4'd4, 2'd0, 32'hFF, 32'h00, 1'b0, 1'b1);
    // R2: borrow 0-1 at 16 bits, then subtract with borrow
    run(4'd2, 2'd1, 32'h0, 32'h1, 1'b0, 1'b1);
    run(4'd3, 2'd2, 32'h5, 32'h5, 1'b1, 1'b1);
    // R3: decrement keeps CF=1 left by previous op
    run(4'd5, 2'd1, 32'h0, 32'h0, 1'b0, 1'b1);
    // R5: negate zero and a nonzero value
    run(4'd7, 2'd0, 32'h0, 32'h0, 1'b0, 1'b1);
    run(4'd7, 2'd2, 32'h8000_0000, 32'h0, 1'b0, 1'b1);
    // R4: compare writes no result
    run(4'd6, 2'd2, 32'h10, 32'h20, 1'b0, 1'b1);
    // R7: NOT with flag write requested
    run(4'd11, 2'd1, 32'h1234_00FF, 32'h0, 1'b0, 1'b1);
    // R6: AND after a carry-setting op
    run(4'd2, 2'd0, 32'h0, 32'h1, 1'b0, 1'b1);
    run(4'd8, 2'd0, 32'hF0, 32'h3C, 1'b0, 1'b1);
    // R10: unused opcode and masked flag write
    run(4'd13, 2'd2, 32'hFFFF_FFFF, 32'h1, 1'b1, 1'b1);
    run(4'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b0);
    // R8: size code 3 behaves as 32 bits
    run(4'd0, 2'd3, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] o;
      logic [31:0] a, b;
      o = ($urandom % 10 == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
      a = $urandom; b = $urandom;
      if ($urandom % 8 == 0) a = a & 32'h8000_000F;
      if ($urandom % 8 == 0) b = a;
      run(o, 2'($urandom % 4), a, b, 1'($urandom), ($urandom % 5) != 0);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule